// File: doc/BRIEF.md
# Byte-Parallel Chained Configuration Slave

This block receives configuration data one byte at a time from a host. The host owns the clock, two active-low selects and an active-low write strobe. The port fills a local byte store of a fixed size. It raises a completion flag once the store is full. When a persistence option is set, the host can later read the store back over the same byte lanes.

Once its own load is complete, the port can forward later traffic to a downstream device in one of two ways. In serial-bypass mode each further byte is shifted out on a one-bit line, and a busy output holds the host off while the shift runs. In select-forward mode the port pulls a downstream chip-select low so that the next byte-wide device takes the bus. A third chain setting forwards nothing. The data lanes are modelled as a separate input, output and output-enable, so the pad ring can form the bidirectional bus.

Top module: `cfg_par_slave`

## Requirements
- R1: A byte is taken only on a rising clock edge where `cfg_mode` is 2'b10 and `cs_n`, `cs1_n` and `wr_n` are all low. A byte presented under any other combination has no effect.
- R2: The first NBYTES bytes taken are stored at addresses 0 upward in arrival order. `done` rises on the edge that stores the last one and then stays high until reset.
- R3: Readback is armed when `done` is high, `chain_sel` is 2'b00, `persist_en` is high and the byte taken equals RB_CMD (default 8'hA5). While armed, with both selects low and `wr_n` high, `d_oe` is high and `d_out` shows the byte at the read pointer. The pointer starts at 0, advances by one on each such edge and wraps after NBYTES-1.
- R4: With `persist_en` low, the readback command is ignored and `d_oe` stays low.
- R5: `d_oe` is low whenever the port is not armed, when either select is high, or when `wr_n` is low. Raising either select disarms readback.
- R6: With `chain_sel` 2'b01 (bypass), a byte taken after `done` drives `sdo` with bit 7 after the next edge, then bits 6 down to 0 on the following seven edges. `sdo` holds bit 0 afterwards.
- R7: `busy` is high for exactly the 8 clock cycles after a bypass byte is taken. Writes presented while `busy` is high are ignored.
- R8: With `chain_sel` 2'b10 (flow-through), `cso_n` falls on the edge after `done` rises and stays low until reset. With any other chain setting it stays high.
- R9: With `chain_sel` 2'b00, a byte taken after `done` that is not the readback command leaves `sdo` low, `cso_n` high and `busy` low.
- R10: A synchronous active-high `rst` clears the byte count, `done`, `busy` and readback arming, sets `cso_n` high and `sdo` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-supplied configuration clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Configuration mode pins; 2'b10 enables this port |
| chain_sel | input | 2 | 00 no forwarding, 01 serial bypass, 10 select forward |
| persist_en | input | 1 | Permits readback of the store |
| cs_n | input | 1 | First active-low select |
| cs1_n | input | 1 | Second active-low select |
| wr_n | input | 1 | Active-low write strobe; high with selects low means read |
| d_in | input | 8 | Byte lanes from the host |
| d_out | output | 8 | Byte lanes toward the host during readback |
| d_oe | output | 1 | Output enable for `d_out` |
| busy | output | 1 | High while the port cannot take a byte |
| done | output | 1 | Own load complete |
| sdo | output | 1 | Serial bypass output, MSB first |
| cso_n | output | 1 | Active-low select for the next byte-wide device |

## Verification
A load counter that is wrong shows up as `done` rising one byte early or late. It also shows up as readback returning bytes in a shifted order, which appears on `d_out` in the first read cycle after arming. A bad bypass shift state first shows up on `sdo` on the edge after a byte is taken, or as `busy` lasting other than eight cycles. A flow-through select that rises again, or falls in the wrong chain mode, shows up on `cso_n` within one cycle.

// File: rtl/cfg_par_pkg.sv
package cfg_par_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        CH_OFF    = 2'b00,
        CH_BYPASS = 2'b01,
        CH_FLOW   = 2'b10
    } chain_e;

    localparam logic [1:0] MODE_SLAVE_PAR = 2'b10;

endpackage

// File: rtl/cfg_strobe_decode.sv
module cfg_strobe_decode (
    input  logic [1:0] cfg_mode,
    input  logic       cs_n,
    input  logic       cs1_n,
    input  logic       wr_n,
    output logic       wr_req,
    output logic       rd_req,
    output logic       sel_both
);
    import cfg_par_pkg::*;

    logic mode_ok;

    always_comb begin
        mode_ok  = (cfg_mode == MODE_SLAVE_PAR);
        sel_both = mode_ok && !cs_n && !cs1_n;
        wr_req   = sel_both && !wr_n;
        rd_req   = sel_both && wr_n;
    end

endmodule

// File: rtl/cfg_byte_store.sv
module cfg_byte_store #(
    parameter int unsigned NBYTES = 16,
    parameter int unsigned W      = 8,
    parameter logic [W-1:0] RB_CMD = 8'hA5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_req,
    input  logic         rd_req,
    input  logic         sel_both,
    input  logic         busy,
    input  logic [1:0]   chain_sel,
    input  logic         persist_en,
    input  logic [W-1:0] d_in,
    output logic         done,
    output logic         fwd_take,
    output logic [W-1:0] d_out,
    output logic         d_oe
);
    import cfg_par_pkg::*;

    localparam int unsigned CW = $clog2(NBYTES + 1);
    localparam int unsigned PW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(NBYTES - 1);
    localparam logic [PW-1:0] LAST_PTR = PW'(NBYTES - 1);

    typedef struct packed {
        logic [NBYTES-1:0][W-1:0] mem;
        logic [CW-1:0]            cnt;
        logic [PW-1:0]            ptr;
        logic                     done;
        logic                     armed;
    } store_t;

    store_t st_d, st_q;
    logic   take;

    always_comb begin
        st_d     = st_q;
        take     = wr_req && !busy;
        fwd_take = take && st_q.done;

        if (take && !st_q.done) begin
            st_d.mem[st_q.cnt[PW-1:0]] = d_in;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST_CNT) begin
                st_d.done = 1'b1;
            end
        end else if (fwd_take && chain_sel == CH_OFF && persist_en
                     && d_in == RB_CMD) begin
            st_d.armed = 1'b1;
            st_d.ptr   = '0;
        end

        if (st_q.armed && rd_req) begin
            st_d.ptr = (st_q.ptr == LAST_PTR) ? '0 : st_q.ptr + 1'b1;
        end

        if (!sel_both) begin
            st_d.armed = 1'b0;
        end

        if (rst) begin
            st_d.cnt   = '0;
            st_d.ptr   = '0;
            st_d.done  = 1'b0;
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        done  = st_q.done;
        d_oe  = st_q.armed && rd_req;
        d_out = st_q.mem[st_q.ptr];
    end

endmodule

// File: rtl/cfg_chain_fwd.sv
module cfg_chain_fwd #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   chain_sel,
    input  logic         done,
    input  logic         fwd_take,
    input  logic [W-1:0] d_in,
    output logic         sdo,
    output logic         busy,
    output logic         cso_n
);
    import cfg_par_pkg::*;

    localparam int unsigned BW = $clog2(W + 1);
    localparam logic [BW-1:0] FULL = BW'(W);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [BW-1:0] bits;
        logic          sdo;
        logic          cso_n;
    } fwd_t;

    fwd_t fw_d, fw_q;

    always_comb begin
        fw_d = fw_q;

        if (fw_q.bits != '0) begin
            fw_d.sdo  = fw_q.sh[W-1];
            fw_d.sh   = {fw_q.sh[W-2:0], 1'b0};
            fw_d.bits = fw_q.bits - 1'b1;
        end else if (fwd_take && chain_sel == CH_BYPASS) begin
            fw_d.sh   = d_in;
            fw_d.bits = FULL;
        end

        if (done && chain_sel == CH_FLOW) begin
            fw_d.cso_n = 1'b0;
        end

        if (rst) begin
            fw_d.sh    = '0;
            fw_d.bits  = '0;
            fw_d.sdo   = 1'b0;
            fw_d.cso_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        fw_q <= fw_d;
    end

    always_comb begin
        sdo   = fw_q.sdo;
        busy  = (fw_q.bits != '0);
        cso_n = fw_q.cso_n;
    end

endmodule

// File: rtl/cfg_par_slave.sv
module cfg_par_slave #(
    parameter int unsigned NBYTES = 16,
    parameter logic [7:0]  RB_CMD = 8'hA5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cfg_mode,
    input  logic [1:0] chain_sel,
    input  logic       persist_en,
    input  logic       cs_n,
    input  logic       cs1_n,
    input  logic       wr_n,
    input  logic [7:0] d_in,
    output logic [7:0] d_out,
    output logic       d_oe,
    output logic       busy,
    output logic       done,
    output logic       sdo,
    output logic       cso_n
);
    import cfg_par_pkg::*;

    logic wr_req, rd_req, sel_both, fwd_take;

    cfg_strobe_decode u_dec (
        .cfg_mode (cfg_mode),
        .cs_n     (cs_n),
        .cs1_n    (cs1_n),
        .wr_n     (wr_n),
        .wr_req   (wr_req),
        .rd_req   (rd_req),
        .sel_both (sel_both)
    );

    cfg_byte_store #(
        .NBYTES (NBYTES),
        .W      (BYTE_W),
        .RB_CMD (RB_CMD)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_req     (wr_req),
        .rd_req     (rd_req),
        .sel_both   (sel_both),
        .busy       (busy),
        .chain_sel  (chain_sel),
        .persist_en (persist_en),
        .d_in       (d_in),
        .done       (done),
        .fwd_take   (fwd_take),
        .d_out      (d_out),
        .d_oe       (d_oe)
    );

    cfg_chain_fwd #(
        .W (BYTE_W)
    ) u_fwd (
        .clk       (clk),
        .rst       (rst),
        .chain_sel (chain_sel),
        .done      (done),
        .fwd_take  (fwd_take),
        .d_in      (d_in),
        .sdo       (sdo),
        .busy      (busy),
        .cso_n     (cso_n)
    );

endmodule

// File: rtl/cfg_par_slave_chk.sv
module cfg_par_slave_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cfg_mode,
    input logic [1:0] chain_sel,
    input logic       persist_en,
    input logic       cs_n,
    input logic       cs1_n,
    input logic       wr_n,
    input logic       d_oe,
    input logic       busy,
    input logic       done,
    input logic       sdo,
    input logic       cso_n
);
    logic [3:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst || !busy) busy_run <= '0;
        else if (busy_run != 4'hF) busy_run <= busy_run + 1'b1;
    end

    p_done_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    p_busy_bypass_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (chain_sel == 2'b01 && done));

    p_busy_len_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_run < 4'd8));

    p_cso_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !cso_n |=> !cso_n);

    p_cso_flow_r8: assert property (@(posedge clk) disable iff (rst)
        !cso_n |-> (chain_sel == 2'b10 && done));

    p_oe_read_r5: assert property (@(posedge clk) disable iff (rst)
        d_oe |-> (!cs_n && !cs1_n && wr_n && cfg_mode == 2'b10));

    p_oe_persist_r4: assert property (@(posedge clk) disable iff (rst)
        d_oe |-> persist_en);

    p_sdo_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (chain_sel != 2'b01) |-> !sdo);

    p_reset_state_r10: assert property (@(posedge clk)
        rst |=> (!done && !busy && cso_n && !sdo && !d_oe));

endmodule

bind cfg_par_slave cfg_par_slave_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_mode   (cfg_mode),
    .chain_sel  (chain_sel),
    .persist_en (persist_en),
    .cs_n       (cs_n),
    .cs1_n      (cs1_n),
    .wr_n       (wr_n),
    .d_oe       (d_oe),
    .busy       (busy),
    .done       (done),
    .sdo        (sdo),
    .cso_n      (cso_n)
);

// File: tb/cfg_par_slave_bench.sv
module cfg_par_slave_bench;

    localparam int unsigned NB = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_mode = 2'b10;
    logic [1:0] chain_sel = 2'b00;
    logic       persist_en = 1'b1;
    logic       cs_n = 1'b1;
    logic       cs1_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] d_in = 8'h00;
    logic [7:0] d_out;
    logic       d_oe, busy, done, sdo, cso_n;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    cfg_par_slave #(.NBYTES(NB), .RB_CMD(8'hA5)) u_cfg_par_slave (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .chain_sel(chain_sel),
        .persist_en(persist_en), .cs_n(cs_n), .cs1_n(cs1_n), .wr_n(wr_n),
        .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .busy(busy), .done(done),
        .sdo(sdo), .cso_n(cso_n)
    );

    // {cs_n, cs1_n, wr_n, cfg_mode[1:0], data[7:0], expected done}
    localparam logic [13:0] VEC [10] = '{
        {3'b000, 2'b10, 8'h11, 1'b0},
        {3'b100, 2'b10, 8'hEE, 1'b0},
        {3'b010, 2'b10, 8'hEE, 1'b0},
        {3'b001, 2'b10, 8'hEE, 1'b0},
        {3'b000, 2'b01, 8'hEE, 1'b0},
        {3'b000, 2'b10, 8'h22, 1'b0},
        {3'b000, 2'b11, 8'hEE, 1'b0},
        {3'b000, 2'b10, 8'h33, 1'b0},
        {3'b000, 2'b10, 8'h44, 1'b1},
        {3'b000, 2'b10, 8'h55, 1'b1}
    };

    localparam logic [7:0] STORED [NB] = '{8'h11, 8'h22, 8'h33, 8'h44};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        cs_n = 1'b1; cs1_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic wbyte(input logic [7:0] b);
        @(negedge clk);
        cs_n = 1'b0; cs1_n = 1'b0; wr_n = 1'b0; d_in = b;
        @(posedge clk); #1;
    endtask

    task automatic do_reset(input logic [1:0] ch, input logic pe);
        @(negedge clk);
        rst = 1'b1; chain_sel = ch; persist_en = pe; cfg_mode = 2'b10;
        cs_n = 1'b1; cs1_n = 1'b1; wr_n = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        chk("R10 done", done, 0);
        chk("R10 busy", busy, 0);
        chk("R10 cso_n", cso_n, 1);
        chk("R10 sdo", sdo, 0);
        chk("R10 d_oe", d_oe, 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // Reset state and table walk: strobe qualification (R1), load order (R2)
        do_reset(2'b00, 1'b1);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            {cs_n, cs1_n, wr_n, cfg_mode, d_in} = VEC[i][13:1];
            @(posedge clk); #1;
            chk($sformatf("R1/R2 done row %0d", i), done, VEC[i][0]);
            chk($sformatf("R5 d_oe row %0d", i), d_oe, 0);
            chk($sformatf("R9 sdo row %0d", i), sdo, 0);
            chk($sformatf("R9 cso_n row %0d", i), cso_n, 1);
            chk($sformatf("R9 busy row %0d", i), busy, 0);
        end
        cfg_mode = 2'b10;

        // Readback with wrap (R3), then disarm on deselect (R5)
        wbyte(8'hA5);
        @(negedge clk);
        wr_n = 1'b1;
        #1;
        chk("R3 d_oe first", d_oe, 1);
        chk("R3 d_out first", d_out, STORED[0]);
        for (int k = 1; k < 6; k++) begin
            @(posedge clk); #1;
            chk("R3 d_oe", d_oe, 1);
            chk($sformatf("R3 d_out idx %0d", k % NB), d_out, STORED[k % NB]);
        end
        @(negedge clk);
        cs_n = 1'b1;
        #1;
        chk("R5 d_oe deselected", d_oe, 0);
        @(negedge clk);
        cs_n = 1'b0;
        @(posedge clk); #1;
        chk("R5 disarmed", d_oe, 0);
        idle();

        // Readback command without persistence (R4)
        do_reset(2'b00, 1'b0);
        for (int i = 0; i < NB; i++) wbyte(8'h60 + 8'(i));
        chk("R2 done after load", done, 1);
        wbyte(8'hA5);
        @(negedge clk);
        wr_n = 1'b1;
        #1;
        chk("R4 d_oe before edge", d_oe, 0);
        @(posedge clk); #1;
        chk("R4 d_oe after edge", d_oe, 0);
        idle();

        // Serial bypass (R6, R7)
        do_reset(2'b01, 1'b1);
        for (int i = 0; i < NB; i++) wbyte(8'h70 + 8'(i));
        chk("R6 sdo idle after load", sdo, 0);
        chk("R8 cso_n high in bypass", cso_n, 1);
        wbyte(8'hB4);
        chk("R7 busy after take", busy, 1);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (k == 3) begin
                wr_n = 1'b0; d_in = 8'hFF;
            end else begin
                wr_n = 1'b1; d_in = 8'hB4;
            end
            @(posedge clk); #1;
            chk($sformatf("R6 sdo bit %0d", 8 - k), sdo, 8'hB4 >> (8 - k) & 1);
            chk($sformatf("R7 busy cycle %0d", k), busy, (k < 8) ? 1 : 0);
        end
        idle();
        @(posedge clk); #1;
        chk("R7 busy released", busy, 0);
        chk("R6 sdo holds bit 0", sdo, 0);

        // Flow-through select (R8)
        do_reset(2'b10, 1'b1);
        for (int i = 0; i < NB; i++) wbyte(8'h80 + 8'(i));
        chk("R2 done flow", done, 1);
        chk("R8 cso_n same edge", cso_n, 1);
        idle();
        @(posedge clk); #1;
        chk("R8 cso_n low", cso_n, 0);
        wbyte(8'h77);
        chk("R8 cso_n stays low", cso_n, 0);
        chk("R8 no busy", busy, 0);
        chk("R8 no sdo", sdo, 0);
        idle();
        do_reset(2'b00, 1'b1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule